// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of a small direct-mapped, write-back cache that sits on a shared snooping bus. It holds a state and a tag per line and turns processor reads and writes into either an immediate completion or a sequence of bus requests. It watches the transactions of the other caches on the same bus and updates its own lines to match. The data array, main memory and the bus arbiter sit outside it. The block only decides states, bus commands and snoop responses.

A processor request is held on `cpu_req` until `cpu_done` pulses. When the request needs the bus, the block raises `bus_req_valid` with a command and an address and waits for `bus_grant`. A fetch also waits for `bus_fill_done`, and at that moment `bus_shared_in` tells it whether another cache kept a copy. A snooped transaction is presented for one cycle on `snp_valid`. In that same cycle the block answers on `snp_shared`, `snp_supply` and `snp_flush`. The arbiter is trusted never to present a snoop in the same cycle as this block's own grant or fill.

Top module: `mesi_coherence_ctrl`

## Requirements
- R1: After reset every line is invalid. `cpu_done`, `bus_req_valid` and all snoop responses are low, and a snoop to any line gets no response. The state code is invalid=0, shared=1, exclusive=2, modified=3. `cpu_addr` is split as tag in the upper bits and line index in the low `IDX_W` bits.
- R2: A read miss issues bus command 0 (read) with the requested address. After the fill the line is shared if `bus_shared_in` was high in the fill cycle, and exclusive otherwise.
- R3: A read that hits in shared, exclusive or modified completes in the cycle after acceptance. It makes no bus request, reports `cpu_hit`=1 and leaves the state unchanged.
- R4: A write that hits in exclusive becomes modified with no bus request. A write that hits in modified stays modified with no bus request.
- R5: A write that hits in shared issues bus command 2 (upgrade). Once granted, the line becomes modified.
- R6: A write miss issues bus command 1 (read with intent to modify). After the fill the line is modified, whatever the value of `bus_shared_in`.
- R7: A miss whose index holds a modified line with a different tag first issues bus command 3 (write-back) at the victim's address, then issues the fetch. A shared or exclusive victim is dropped without bus traffic.
- R8: A snooped read (command 0) that hits raises `snp_shared`. An exclusive line moves to shared and a shared line stays shared.
- R9: A snooped read that hits a modified line raises `snp_supply` and `snp_shared`, so the line supplies the data and memory is updated, and the line moves to shared.
- R10: A snooped command 1 or 2 that hits makes the line invalid. `snp_flush` is raised only if the line was modified. `snp_shared` and `snp_supply` stay low.
- R11: A snoop that misses (invalid line or different tag) or carries command 3 raises no response and changes no state.
- R12: A pending bus request is re-derived when a snoop changes its line before the grant. A pending upgrade whose line was invalidated becomes command 1. A pending write-back whose victim is no longer modified is dropped in favour of the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Request was served without a fetch |
| cpu_line_st | output | 2 | Line state after the request |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_req_addr | output | ADDR_W | Address of the bus request |
| bus_grant | input | 1 | Arbiter accepts the pending request |
| bus_fill_done | input | 1 | Fetched line has arrived |
| bus_shared_in | input | 1 | Another cache kept a copy (sampled with the fill) |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_req_cmd` |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds the line (read snoop) |
| snp_supply | output | 1 | This cache supplies a dirty line; memory read suppressed |
| snp_flush | output | 1 | Dirty line written back before invalidation |

## Verification
The processor side is swept over every starting state, both access types, a matching tag against a conflicting tag, and both levels of the shared-response input. This separates hit handling from miss handling, exclusive fills from shared fills, and a dirty victim from a clean one. The snoop side is swept over every starting state, all four commands, and a matching tag against a different one. After each snoop, a processor read of the same line shows which state the snoop left behind. Two directed races place a snoop between a request and its grant to check that a stale upgrade or write-back is re-derived.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    BC_READ  = 2'b00,
    BC_RWITM = 2'b01,
    BC_UPGR  = 2'b10,
    BC_WBACK = 2'b11
  } bus_cmd_t;

  typedef enum logic [2:0] {
    ACT_KEEP,
    ACT_TO_M,
    ACT_UPGR,
    ACT_FETCH,
    ACT_EVICT
  } cpu_act_t;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_EVICT,
    FS_FETCH,
    FS_FILL,
    FS_UPGR
  } fsm_t;

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] a_idx,
  output line_st_t         a_st,
  output logic [TAG_W-1:0] a_tag,
  input  logic [IDX_W-1:0] b_idx,
  output line_st_t         b_st,
  output logic [TAG_W-1:0] b_tag,
  input  logic             p_we,
  input  logic [IDX_W-1:0] p_idx,
  input  logic [TAG_W-1:0] p_tag,
  input  line_st_t         p_st,
  input  logic             s_we,
  input  logic [IDX_W-1:0] s_idx,
  input  line_st_t         s_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_t         st_v  [LINES];
  logic [TAG_W-1:0] tag_v [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_t         st_r;
    logic [TAG_W-1:0] tag_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        st_r  <= ST_I;
        tag_r <= '0;
      end else if (p_we && p_idx == IDX_W'(g)) begin
        st_r  <= p_st;
        tag_r <= p_tag;
      end else if (s_we && s_idx == IDX_W'(g)) begin
        st_r  <= s_st;
      end
    end

    assign st_v[g]  = st_r;
    assign tag_v[g] = tag_r;
  end

  assign a_st  = st_v[a_idx];
  assign a_tag = tag_v[a_idx];
  assign b_st  = st_v[b_idx];
  assign b_tag = tag_v[b_idx];

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
    !(p_we && s_we && p_idx == s_idx)); // R12

endmodule

// File: rtl/mesi_cpu_decode.sv
module mesi_cpu_decode
  import mesi_pkg::*;
(
  input  logic     hit,
  input  logic     wr,
  input  line_st_t st,
  output cpu_act_t act
);
  always_comb begin
    if (!hit) begin
      act = (st == ST_M) ? ACT_EVICT : ACT_FETCH;
    end else if (!wr || st == ST_M) begin
      act = ACT_KEEP;
    end else if (st == ST_E) begin
      act = ACT_TO_M;
    end else begin
      act = ACT_UPGR;
    end
  end
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
(
  input  logic     valid,
  input  bus_cmd_t cmd,
  input  logic     hit,
  input  line_st_t st,
  output logic     upd,
  output line_st_t nst,
  output logic     shared,
  output logic     supply,
  output logic     flush
);
  always_comb begin
    upd    = 1'b0;
    nst    = st;
    shared = 1'b0;
    supply = 1'b0;
    flush  = 1'b0;
    if (valid && hit) begin
      case (cmd)
        BC_READ: begin
          shared = 1'b1;
          supply = (st == ST_M);
          nst    = ST_S;
          upd    = (st != ST_S);
        end
        BC_RWITM, BC_UPGR: begin
          flush = (st == ST_M);
          nst   = ST_I;
          upd   = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_coherence_ctrl.sv
module mesi_coherence_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic [1:0]        cpu_line_st,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_grant,
  input  logic              bus_fill_done,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic              snp_flush
);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_t              fsm;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_wr;
  line_st_t          line_st_q;
  bus_cmd_t          cmd_q;

  logic [IDX_W-1:0]  cpu_idx, cur_idx, a_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, cur_tag, snp_tag;
  line_st_t          a_st, b_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic              a_hit, b_hit, accept;
  cpu_act_t          act;
  bus_cmd_t          fetch_cmd;
  line_st_t          fill_st;

  logic              p_we;
  line_st_t          p_st;
  logic              s_we;
  line_st_t          s_st;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign cur_idx = cur_addr[IDX_W-1:0];
  assign cur_tag = cur_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  assign a_idx  = (fsm == FS_IDLE) ? cpu_idx : cur_idx;
  assign a_hit  = (a_st != ST_I) && (a_tag == cpu_tag);
  assign b_hit  = (b_st != ST_I) && (b_tag == snp_tag);
  assign accept = (fsm == FS_IDLE) && cpu_req && !snp_valid;

  assign fetch_cmd = cur_wr ? BC_RWITM : BC_READ;
  assign fill_st   = cur_wr ? ST_M : (bus_shared_in ? ST_S : ST_E);

  mesi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
    .clk   (clk),
    .rst   (rst),
    .a_idx (a_idx),
    .a_st  (a_st),
    .a_tag (a_tag),
    .b_idx (snp_idx),
    .b_st  (b_st),
    .b_tag (b_tag),
    .p_we  (p_we),
    .p_idx (a_idx),
    .p_tag ((fsm == FS_IDLE) ? cpu_tag : cur_tag),
    .p_st  (p_st),
    .s_we  (s_we),
    .s_idx (snp_idx),
    .s_st  (s_st)
  );

  mesi_cpu_decode u_dec (
    .hit (a_hit),
    .wr  (cpu_wr),
    .st  (a_st),
    .act (act)
  );

  mesi_snoop_resp u_snp (
    .valid  (snp_valid),
    .cmd    (bus_cmd_t'(snp_cmd)),
    .hit    (b_hit),
    .st     (b_st),
    .upd    (s_we),
    .nst    (s_st),
    .shared (snp_shared),
    .supply (snp_supply),
    .flush  (snp_flush)
  );

  // line-state writes from the processor side
  always_comb begin
    p_we = 1'b0;
    p_st = a_st;
    case (fsm)
      FS_IDLE:  if (accept && act == ACT_TO_M) begin p_we = 1'b1; p_st = ST_M; end
      FS_EVICT: if (a_st == ST_M && bus_grant) begin p_we = 1'b1; p_st = ST_I; end
      FS_FILL:  if (bus_fill_done) begin p_we = 1'b1; p_st = fill_st; end
      FS_UPGR:  if (a_st == ST_S && bus_grant) begin p_we = 1'b1; p_st = ST_M; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm           <= FS_IDLE;
      cur_addr      <= '0;
      cur_wr        <= 1'b0;
      cpu_done      <= 1'b0;
      cpu_hit       <= 1'b0;
      line_st_q     <= ST_I;
      bus_req_valid <= 1'b0;
      cmd_q         <= BC_READ;
      bus_req_addr  <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (fsm)
        FS_IDLE: begin
          if (accept) begin
            cur_addr <= cpu_addr;
            cur_wr   <= cpu_wr;
            case (act)
              ACT_KEEP: begin
                cpu_done  <= 1'b1;
                cpu_hit   <= 1'b1;
                line_st_q <= a_st;
              end
              ACT_TO_M: begin
                cpu_done  <= 1'b1;
                cpu_hit   <= 1'b1;
                line_st_q <= ST_M;
              end
              ACT_UPGR: begin
                fsm           <= FS_UPGR;
                cpu_hit       <= 1'b1;
                bus_req_valid <= 1'b1;
                cmd_q         <= BC_UPGR;
                bus_req_addr  <= cpu_addr;
              end
              ACT_EVICT: begin
                fsm           <= FS_EVICT;
                cpu_hit       <= 1'b0;
                bus_req_valid <= 1'b1;
                cmd_q         <= BC_WBACK;
                bus_req_addr  <= {a_tag, cpu_idx};
              end
              default: begin
                fsm           <= FS_FETCH;
                cpu_hit       <= 1'b0;
                bus_req_valid <= 1'b1;
                cmd_q         <= cpu_wr ? BC_RWITM : BC_READ;
                bus_req_addr  <= cpu_addr;
              end
            endcase
          end
        end
        FS_EVICT: begin
          if (a_st != ST_M || bus_grant) begin
            fsm          <= FS_FETCH;
            cmd_q        <= fetch_cmd;
            bus_req_addr <= cur_addr;
          end
        end
        FS_FETCH: begin
          if (bus_grant) begin
            fsm           <= FS_FILL;
            bus_req_valid <= 1'b0;
          end
        end
        FS_FILL: begin
          if (bus_fill_done) begin
            fsm       <= FS_IDLE;
            cpu_done  <= 1'b1;
            line_st_q <= fill_st;
          end
        end
        FS_UPGR: begin
          if (a_st != ST_S) begin
            fsm     <= FS_FETCH;
            cmd_q   <= BC_RWITM;
            cpu_hit <= 1'b0;
          end else if (bus_grant) begin
            fsm           <= FS_IDLE;
            bus_req_valid <= 1'b0;
            cpu_done      <= 1'b1;
            line_st_q     <= ST_M;
          end
        end
        default: fsm <= FS_IDLE;
      endcase
    end
  end

  assign cpu_line_st = line_st_q;
  assign bus_req_cmd = cmd_q;

  AST_FILL_RESULT: assert property (@(posedge clk) disable iff (rst)
    (fsm == FS_FILL && bus_fill_done) |=> cpu_done &&
      (cpu_line_st == ($past(cur_wr) ? 2'd3 : ($past(bus_shared_in) ? 2'd1 : 2'd2)))); // R2
  AST_READ_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (accept && a_hit && !cpu_wr) |=> cpu_done && !bus_req_valid &&
      cpu_line_st == $past(a_st)); // R3
  AST_SILENT_UPGRADE: assert property (@(posedge clk) disable iff (rst)
    (accept && a_hit && cpu_wr && a_st == ST_E) |=> cpu_done && !bus_req_valid &&
      cpu_line_st == 2'd3); // R4
  AST_WB_BEFORE_FETCH: assert property (@(posedge clk) disable iff (rst)
    (fsm == FS_EVICT && a_st == ST_M && bus_grant) |=> bus_req_valid &&
      (bus_req_cmd == 2'd0 || bus_req_cmd == 2'd1)); // R7
  AST_SUPPLY_IS_SHARED: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> snp_shared && !snp_flush && snp_valid); // R9
  AST_FLUSH_ONLY_WRITE_SNOOP: assert property (@(posedge clk) disable iff (rst)
    snp_flush |-> snp_valid && snp_cmd != 2'd0 && !snp_shared); // R10

endmodule

// File: tb/mesi_coherence_ctrl_tb_top.sv
`timescale 1ns/1ps
module mesi_coherence_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_addr = '0;
  logic       cpu_done, cpu_hit;
  logic [1:0] cpu_line_st;
  logic       bus_req_valid;
  logic [1:0] bus_req_cmd;
  logic [7:0] bus_req_addr;
  logic       bus_grant = 1'b0, bus_fill_done = 1'b0, bus_shared_in = 1'b0;
  logic       snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0;
  logic [7:0] snp_addr = '0;
  logic       snp_shared, snp_supply, snp_flush;

  always #2 clk = ~clk;

  mesi_coherence_ctrl #(.ADDR_W(8), .IDX_W(2)) dut_i (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_line_st(cpu_line_st),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_grant(bus_grant), .bus_fill_done(bus_fill_done), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_flush(snp_flush)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference model: 0=I 1=S 2=E 3=M
  logic [1:0] mst  [4];
  logic [5:0] mtag [4];

  task automatic chk(input bit ok, input string lbl, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", lbl, what, act, exp);
    end
  endtask

  task automatic grant_once();
    bus_grant = 1'b1;
    @(posedge clk); #1;
    bus_grant = 1'b0;
  endtask

  task automatic fill_once(input logic sh);
    bus_fill_done = 1'b1;
    bus_shared_in = sh;
    @(posedge clk); #1;
    bus_fill_done = 1'b0;
    bus_shared_in = 1'b0;
  endtask

  task automatic cpu_op(input logic wr, input logic [7:0] a, input logic sh);
    int         idx;
    logic [5:0] tg;
    logic       ehit;
    int         ecnt;
    logic [1:0] ec0, ec1, est;
    logic [7:0] ea0;
    string      lbl;
    int         n;
    logic [1:0] gc [3];
    logic [7:0] ga [3];
    logic       ghit;
    logic [1:0] gst;
    bit         fillp;
    int         guard;
    idx = int'(a[1:0]);
    tg  = a[7:2];
    ehit = (mst[idx] != 2'd0) && (mtag[idx] == tg);
    ec0 = 2'd0; ec1 = 2'd0; ea0 = a; ecnt = 0;
    if (ehit) begin
      if (!wr) begin est = mst[idx]; lbl = "R3"; end
      else if (mst[idx] == 2'd1) begin est = 2'd3; ecnt = 1; ec0 = 2'd2; lbl = "R5"; end
      else begin est = 2'd3; lbl = "R4"; end
    end else begin
      est = wr ? 2'd3 : (sh ? 2'd1 : 2'd2);
      lbl = wr ? "R6" : "R2";
      if (mst[idx] == 2'd3) begin
        ecnt = 2; ec0 = 2'd3; ea0 = {mtag[idx], a[1:0]}; ec1 = wr ? 2'd1 : 2'd0;
        lbl = {lbl, "/R7"};
      end else begin
        ecnt = 1; ec0 = wr ? 2'd1 : 2'd0;
      end
    end
    n = 0; fillp = 0; guard = 0; ghit = 0; gst = 0;
    for (int k = 0; k < 3; k++) begin gc[k] = 0; ga[k] = 0; end
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a;
    forever begin
      @(negedge clk);
      guard++;
      if (cpu_done) begin ghit = cpu_hit; gst = cpu_line_st; cpu_req = 1'b0; break; end
      if (guard > 60) begin chk(0, lbl, "no completion", 0, 1); cpu_req = 1'b0; break; end
      if (bus_req_valid) begin
        if (n < 3) begin gc[n] = bus_req_cmd; ga[n] = bus_req_addr; end
        n++;
        fillp = (bus_req_cmd == 2'd0) || (bus_req_cmd == 2'd1);
        grant_once();
      end else if (fillp) begin
        fill_once(sh);
        fillp = 0;
      end
    end
    chk(ghit == ehit, lbl, "cpu_hit", int'(ghit), int'(ehit));
    chk(n == ecnt, lbl, "bus request count", n, ecnt);
    if (ecnt >= 1) begin
      chk(gc[0] == ec0, lbl, "first bus cmd", int'(gc[0]), int'(ec0));
      chk(ga[0] == ea0, lbl, "first bus addr", int'(ga[0]), int'(ea0));
    end
    if (ecnt == 2) begin
      chk(gc[1] == ec1, lbl, "second bus cmd", int'(gc[1]), int'(ec1));
      chk(ga[1] == a, lbl, "second bus addr", int'(ga[1]), int'(a));
    end
    chk(gst == est, lbl, "line state", int'(gst), int'(est));
    mst[idx]  = est;
    mtag[idx] = tg;
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [7:0] a, input string lbl_in);
    int         idx;
    logic       ehit;
    logic       esh, esup, efl;
    logic [1:0] enst;
    logic       gsh, gsup, gfl;
    string      lbl;
    idx  = int'(a[1:0]);
    ehit = (mst[idx] != 2'd0) && (mtag[idx] == a[7:2]);
    esh = 0; esup = 0; efl = 0; enst = mst[idx];
    if (ehit && cmd == 2'd0) begin
      esh = 1; esup = (mst[idx] == 2'd3); enst = 2'd1;
    end else if (ehit && (cmd == 2'd1 || cmd == 2'd2)) begin
      efl = (mst[idx] == 2'd3); enst = 2'd0;
    end
    if (lbl_in != "") lbl = lbl_in;
    else if (!ehit || cmd == 2'd3) lbl = "R11";
    else if (cmd == 2'd0) lbl = (mst[idx] == 2'd3) ? "R9" : "R8";
    else lbl = "R10";
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
    #1;
    gsh = snp_shared; gsup = snp_supply; gfl = snp_flush;
    @(posedge clk); #1;
    snp_valid = 1'b0;
    chk(gsh == esh, lbl, "snp_shared", int'(gsh), int'(esh));
    chk(gsup == esup, lbl, "snp_supply", int'(gsup), int'(esup));
    chk(gfl == efl, lbl, "snp_flush", int'(gfl), int'(efl));
    mst[idx] = enst;
  endtask

  task automatic make_line(input int idx, input logic [5:0] tg, input int s);
    logic [7:0] a;
    if (mst[idx] != 2'd0) snoop(2'd1, {mtag[idx], 2'(idx)}, "R10");
    a = {tg, 2'(idx)};
    case (s)
      1: cpu_op(1'b0, a, 1'b1);
      2: cpu_op(1'b0, a, 1'b0);
      3: cpu_op(1'b1, a, 1'b0);
      default: ;
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mst[i] = 2'd0; mtag[i] = 6'd0; end
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(cpu_done == 0, "R1", "cpu_done", int'(cpu_done), 0);
    chk(bus_req_valid == 0, "R1", "bus_req_valid", int'(bus_req_valid), 0);
    chk(cpu_line_st == 0, "R1", "cpu_line_st", int'(cpu_line_st), 0);
    for (int i = 0; i < 4; i++) snoop(2'd0, {6'd0, 2'(i)}, "R1");

    // processor sweep: start state x access x tag match x shared response
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++)
        for (int m = 0; m < 2; m++)
          for (int sh = 0; sh < 2; sh++) begin
            int idx;
            idx = (s + w + m) % 4;
            make_line(idx, 6'd5, s);
            cpu_op(w[0], {(m == 0) ? 6'd5 : 6'd9, 2'(idx)}, sh[0]);
          end

    // snoop sweep: start state x command x tag match, then read back via a processor read
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 4; c++)
        for (int m = 0; m < 2; m++) begin
          int idx;
          idx = (s + c) % 4;
          make_line(idx, 6'd5, s);
          snoop(2'(c), {(m == 0) ? 6'd5 : 6'd12, 2'(idx)}, "");
          cpu_op(1'b0, {6'd5, 2'(idx)}, 1'b0);
        end

    // R12: upgrade invalidated by a snoop before its grant
    begin
      make_line(2, 6'd7, 1);
      @(negedge clk);
      cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = {6'd7, 2'd2};
      @(negedge clk);
      chk(bus_req_valid && bus_req_cmd == 2'd2, "R12", "upgrade pending cmd",
          int'(bus_req_cmd), 2);
      snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = {6'd7, 2'd2};
      @(posedge clk); #1;
      snp_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(bus_req_valid && bus_req_cmd == 2'd1, "R12", "re-derived cmd",
          int'(bus_req_cmd), 1);
      grant_once();
      @(negedge clk);
      fill_once(1'b1);
      @(negedge clk);
      chk(cpu_done == 1, "R12", "done after refetch", int'(cpu_done), 1);
      chk(cpu_line_st == 2'd3, "R12", "state after refetch", int'(cpu_line_st), 3);
      chk(cpu_hit == 0, "R12", "hit flag after refetch", int'(cpu_hit), 0);
      cpu_req = 1'b0;
      mst[2] = 2'd3; mtag[2] = 6'd7;
    end

    // R12: queued write-back dropped after a snoop supplied the dirty victim
    begin
      make_line(1, 6'd3, 3);
      @(negedge clk);
      cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = {6'd4, 2'd1};
      @(negedge clk);
      chk(bus_req_valid && bus_req_cmd == 2'd3, "R12", "write-back pending cmd",
          int'(bus_req_cmd), 3);
      snp_valid = 1'b1; snp_cmd = 2'd0; snp_addr = {6'd3, 2'd1};
      #1;
      chk(snp_supply == 1, "R12", "victim supplies", int'(snp_supply), 1);
      @(posedge clk); #1;
      snp_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(bus_req_valid && bus_req_cmd == 2'd0, "R12", "write-back skipped",
          int'(bus_req_cmd), 0);
      chk(bus_req_addr == {6'd4, 2'd1}, "R12", "fetch addr",
          int'(bus_req_addr), int'({6'd4, 2'd1}));
      grant_once();
      @(negedge clk);
      fill_once(1'b0);
      @(negedge clk);
      chk(cpu_done == 1 && cpu_line_st == 2'd2, "R12", "fill state",
          int'(cpu_line_st), 2);
      cpu_req = 1'b0;
      mst[1] = 2'd2; mtag[1] = 6'd4;
      snoop(2'd0, {6'd3, 2'd1}, "R12");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule